// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block follows the state of one DRAM bank inside a memory controller. It watches the stream of commands the controller actually puts on the bus. From that stream it works out whether its bank has a row open, and which row that is.

A scheduler hands the block one pending command and the cycle in which that command may first go out. The block holds the command and offers it to the command arbiter only in the exact cycle named by the scheduler. It makes no offer while the refresh logic holds the bank blocked.

Commands addressed to the whole rank update every bank of that rank. These are precharge-all and all-bank refresh. A refresh command, all-bank or per-bank, ends the refresh block. The bank's rank and bank-group indices come from its bank ID, so the arbiter can route rank-wide commands.

Top module: `dram_bank_tracker`

## Requirements
- R1: When a pending command exists, the free-running cycle input `now` equals its target cycle at a clock edge, and the block flag is clear, `req_cmd`/`req_row` show that command and row from the next cycle, for one cycle only. In every other cycle `req_cmd` is NOP (code 0) and `req_row` is 0.
- R2: An issued ACT (code 1) to this bank sets `bank_open` and latches `cmd_row` into `open_row`, visible the cycle after issue.
- R3: A PRE (code 2) to this bank, or a PREA (code 3) carrying the ID of any bank in the same rank, clears `bank_open`. A PRE to another bank or a PREA to another rank has no effect.
- R4: RD (code 4) and WR (code 6) to this bank leave it open. RDA (code 5) and WRA (code 7) close it. Any ACT, PRE, RD, RDA, WR or WRA to this bank retires the pending command, so no offer follows at its target cycle.
- R5: `block_req` sets the block flag. REFA (code 8) addressed to a bank of the same rank, or REFB (code 9) to this bank, clears it. When a set and a clear arrive in the same cycle, the set wins. REFA to another rank and REFB to another bank leave the flag set.
- R6: `rank_idx` equals BANK_ID / BANKS_PER_RANK and `group_idx` equals BANK_ID / BANKS_PER_GROUP. With the defaults (bank 13, 8 per rank, 4 per group) these are 1 and 3.
- R7: An issued command with a code from 10 to 15 sets `cmd_err`, which then stays set until reset.
- R8: After reset the bank is closed, `open_row` is 0, no command is pending, the block flag is clear, `req_cmd` is NOP and `cmd_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | CYC_W | Current controller cycle |
| cmd_valid | input | 1 | A command was issued on the bus this cycle |
| cmd_code | input | 4 | Code of the issued command |
| cmd_bank | input | log2(NUM_BANKS) | Global bank ID of the issued command |
| cmd_row | input | ROW_W | Row of the issued command |
| block_req | input | 1 | Refresh logic asks to block this bank |
| sched_load | input | 1 | Load a new pending command |
| sched_cmd | input | 4 | Pending command code |
| sched_row | input | ROW_W | Pending command row |
| sched_cycle | input | CYC_W | Target issue cycle |
| req_cmd | output | 4 | Offered command, NOP when none |
| req_row | output | ROW_W | Row of the offered command |
| bank_open | output | 1 | 1 when a row is open |
| open_row | output | ROW_W | Currently open row |
| cmd_err | output | 1 | Sticky unsupported-code flag |
| rank_idx | output | RANK_W | Rank this bank belongs to |
| group_idx | output | GROUP_W | Bank group this bank belongs to |

## Verification
The bench issues precharge-all and all-bank refresh with bank IDs from the same rank and from the other rank. A tracker that decoded the rank incorrectly would close the bank or unblock it when it should not, or ignore the command. It sets and clears the block in the same cycle; a design where the clear wins would offer the held command while refresh still owns the bank. It retires a pending command before its target cycle; a design that does not retire would offer a command that has already gone out. It checks that an offer lasts one cycle at the exact target, which catches a compare that is late, early or repeats the offer.

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int NUM_BANKS       = 16,
  parameter int BANKS_PER_RANK  = 8,
  parameter int BANKS_PER_GROUP = 4,
  parameter int BANK_ID         = 13,
  parameter int ROW_W           = 14,
  parameter int CYC_W           = 16,
  localparam int BANK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int RANK_W  = (NUM_BANKS / BANKS_PER_RANK > 1) ? $clog2(NUM_BANKS / BANKS_PER_RANK) : 1,
  localparam int GROUP_W = (NUM_BANKS / BANKS_PER_GROUP > 1) ? $clog2(NUM_BANKS / BANKS_PER_GROUP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CYC_W-1:0]   now,
  input  logic               cmd_valid,
  input  logic [3:0]         cmd_code,
  input  logic [BANK_W-1:0]  cmd_bank,
  input  logic [ROW_W-1:0]   cmd_row,
  input  logic               block_req,
  input  logic               sched_load,
  input  logic [3:0]         sched_cmd,
  input  logic [ROW_W-1:0]   sched_row,
  input  logic [CYC_W-1:0]   sched_cycle,
  output logic [3:0]         req_cmd,
  output logic [ROW_W-1:0]   req_row,
  output logic               bank_open,
  output logic [ROW_W-1:0]   open_row,
  output logic               cmd_err,
  output logic [RANK_W-1:0]  rank_idx,
  output logic [GROUP_W-1:0] group_idx
);
  localparam logic [3:0] C_NOP = 4'd0, C_ACT = 4'd1, C_PRE = 4'd2, C_PREA = 4'd3,
                         C_RD = 4'd4, C_RDA = 4'd5, C_WR = 4'd6, C_WRA = 4'd7,
                         C_REFA = 4'd8, C_REFB = 4'd9;
  localparam int RANK_ID  = BANK_ID / BANKS_PER_RANK;
  localparam int GROUP_ID = BANK_ID / BANKS_PER_GROUP;

  logic               blk, pend_vld;
  logic [3:0]         pend_cmd;
  logic [ROW_W-1:0]   pend_row;
  logic [CYC_W-1:0]   pend_cyc;
  logic               bank_hit, rank_hit, retire, blk_clr, offer;

  assign rank_idx  = RANK_W'(RANK_ID);
  assign group_idx = GROUP_W'(GROUP_ID);

  assign bank_hit = cmd_valid && (int'(cmd_bank) == BANK_ID);
  assign rank_hit = cmd_valid && ((int'(cmd_bank) / BANKS_PER_RANK) == RANK_ID);
  assign retire   = bank_hit && (cmd_code inside {C_ACT, C_PRE, C_RD, C_RDA, C_WR, C_WRA});
  assign blk_clr  = (rank_hit && cmd_code == C_REFA) || (bank_hit && cmd_code == C_REFB);
  assign offer    = pend_vld && (now == pend_cyc) && !blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open <= 1'b0;
      open_row  <= '0;
      blk       <= 1'b0;
      pend_vld  <= 1'b0;
      pend_cmd  <= C_NOP;
      pend_row  <= '0;
      pend_cyc  <= '0;
      req_cmd   <= C_NOP;
      req_row   <= '0;
      cmd_err   <= 1'b0;
    end else begin
      if (bank_hit && cmd_code == C_ACT) begin
        bank_open <= 1'b1;
        open_row  <= cmd_row;
      end
      if (bank_hit && (cmd_code inside {C_PRE, C_RDA, C_WRA}))
        bank_open <= 1'b0;
      if (rank_hit && cmd_code == C_PREA)
        bank_open <= 1'b0;

      if (retire) pend_vld <= 1'b0;
      if (sched_load) begin
        pend_vld <= 1'b1;
        pend_cmd <= sched_cmd;
        pend_row <= sched_row;
        pend_cyc <= sched_cycle;
      end

      if (blk_clr)   blk <= 1'b0;
      if (block_req) blk <= 1'b1;

      req_cmd <= offer ? pend_cmd : C_NOP;
      req_row <= offer ? pend_row : '0;

      if (cmd_valid && cmd_code > C_REFB) cmd_err <= 1'b1;
    end
  end

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit && cmd_code == C_ACT |=> bank_open && open_row == $past(cmd_row));

  assert_pre_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_hit && cmd_code == C_PRE) || (rank_hit && cmd_code == C_PREA) |=> !bank_open);

  assert_autopre_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit && (cmd_code == C_RDA || cmd_code == C_WRA) |=> !bank_open);

  assert_rdwr_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit && (cmd_code == C_RD || cmd_code == C_WR) |=> bank_open == $past(bank_open));

  assert_blocked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    block_req ##1 !blk_clr |=> req_cmd == C_NOP);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
endmodule

// File: tb/test_dram_bank_tracker.sv
module test_dram_bank_tracker;
  localparam int ROW_W = 14;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             cmd_valid, block_req, sched_load;
  logic [3:0]       cmd_code, cmd_bank, sched_cmd;
  logic [ROW_W-1:0] cmd_row, sched_row;
  logic [15:0]      sched_cycle, now;
  logic [3:0]       req_cmd;
  logic [ROW_W-1:0] req_row, open_row;
  logic             bank_open, cmd_err;
  logic [0:0]       rank_idx;
  logic [1:0]       group_idx;

  dram_bank_tracker i_dram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .now(now), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .block_req(block_req), .sched_load(sched_load),
    .sched_cmd(sched_cmd), .sched_row(sched_row), .sched_cycle(sched_cycle),
    .req_cmd(req_cmd), .req_row(req_row), .bank_open(bank_open), .open_row(open_row),
    .cmd_err(cmd_err), .rank_idx(rank_idx), .group_idx(group_idx));

  typedef struct {
    string            tag;
    logic [3:0]       rc;
    logic [ROW_W-1:0] rr;
    logic             op;
    logic [ROW_W-1:0] orow;
    logic             er;
  } exp_t;

  exp_t q[$];
  int compared = 0, mism = 0, t = 0;
  logic e_open = 1'b0, e_err = 1'b0;
  logic [ROW_W-1:0] e_row = '0;

  task automatic step(string tag, bit v, logic [3:0] c, int b, int row, bit br,
                      bit ld, logic [3:0] lc, int lrow, int dt, logic [3:0] erc, int erow);
    @(negedge clk);
    cmd_valid = v; cmd_code = c; cmd_bank = b[3:0]; cmd_row = row[ROW_W-1:0];
    block_req = br; sched_load = ld; sched_cmd = lc; sched_row = lrow[ROW_W-1:0];
    sched_cycle = 16'(t + dt); now = 16'(t); t++;
    q.push_back('{tag, erc, erow[ROW_W-1:0], e_open, e_row, e_err});
  endtask

  task automatic idle(string tag);                  step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic issue(string tag, logic [3:0] c, int b, int row);
                                                    step(tag, 1, c, b, row, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic load(string tag, logic [3:0] c, int row, int dt);
                                                    step(tag, 0, 0, 0, 0, 0, 1, c, row, dt, 0, 0); endtask
  task automatic offer(string tag, logic [3:0] c, int row);
                                                    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, c, row); endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compared++;
        if ({req_cmd, req_row, bank_open, open_row, cmd_err} !== {e.rc, e.rr, e.op, e.orow, e.er}) begin
          mism++;
          $display("FAIL %s: got cmd=%0d row=%h open=%b orow=%h err=%b exp cmd=%0d row=%h open=%b orow=%h err=%b",
                   e.tag, req_cmd, req_row, bank_open, open_row, cmd_err, e.rc, e.rr, e.op, e.orow, e.er);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    mism++;
    $display("FAIL watchdog: got hang exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    cmd_valid = 0; cmd_code = 0; cmd_bank = 0; cmd_row = 0; block_req = 0;
    sched_load = 0; sched_cmd = 0; sched_row = 0; sched_cycle = 0; now = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compared++;
    if ({req_cmd, req_row, bank_open, open_row, cmd_err} !== '0) begin
      mism++;
      $display("FAIL R8 reset: got cmd=%0d open=%b orow=%h err=%b exp all zero", req_cmd, bank_open, open_row, cmd_err);
    end
    compared++;
    if (rank_idx !== 1'd1 || group_idx !== 2'd3) begin
      mism++;
      $display("FAIL R6 indices: got rank=%0d group=%0d exp rank=1 group=3", rank_idx, group_idx);
    end

    load("R1 load act", 1, 'h123, 2);
    idle("R1 before target");
    offer("R1 offer act", 1, 'h123);
    e_open = 1; e_row = 'h123;
    issue("R2 act issued", 1, 13, 'h123);
    load("R1 load rd", 4, 'h123, 1);
    offer("R1 offer rd", 4, 'h123);
    issue("R4 rd keeps open", 4, 13, 'h123);
    load("R4 load for retire", 4, 'h123, 2);
    issue("R4 wr retires", 6, 13, 'h123);
    idle("R4 retired no offer");
    load("R5 load wr", 6, 'h123, 2);
    step("R5 block set", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle("R5 blocked at target");
    issue("R5 refb other bank", 9, 9, 0);
    step("R5 refa other rank", 1, 8, 2, 0, 0, 1, 6, 'h123, 1, 0, 0);
    idle("R5 still blocked");
    step("R5 refa own rank", 1, 8, 9, 0, 0, 1, 6, 'h123, 2, 0, 0);
    idle("R5 unblocked wait");
    offer("R5 offer after clear", 6, 'h123);
    e_open = 0;
    issue("R4 wra closes", 7, 13, 'h123);
    e_open = 1; e_row = 'h2AA;
    issue("R2 act new row", 1, 13, 'h2AA);
    issue("R3 pre other bank", 2, 12, 0);
    issue("R3 prea other rank", 3, 3, 0);
    e_open = 0;
    issue("R3 prea own rank", 3, 8, 0);
    e_open = 1; e_row = 'h3FF;
    issue("R2 act row 3ff", 1, 13, 'h3FF);
    e_open = 0;
    issue("R3 pre own bank", 2, 13, 0);
    step("R5 set beats clear", 1, 9, 13, 0, 1, 1, 1, 'h7, 2, 0, 0);
    idle("R5 wait");
    idle("R5 set won blocked");
    step("R5 refb own bank", 1, 9, 13, 0, 0, 1, 1, 'h7, 2, 0, 0);
    idle("R1 wait");
    offer("R1 offer after refb", 1, 'h7);
    idle("R1 single cycle");
    e_err = 1;
    issue("R7 bad code", 12, 13, 0);
    issue("R7 sticky after nop", 0, 13, 0);
    idle("R7 sticky idle");
    wait (q.size() == 0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule